// File: doc/BRIEF.md
# Bus-Master Channel Control Registers

This block is the register set a host uses to steer one bus-master DMA channel. It holds a command byte, a status byte and a 32-bit pointer to the descriptor table. It turns command writes into one-cycle start and cancel requests for the DMA engine, and it loads the engine's current descriptor pointer from the table pointer.

The block also collects the device interrupt. The host interrupt line follows the device line directly. A rising device interrupt sets a sticky status flag, which the host clears by writing one to it. The engine reports completion together with a "more work pending" flag, and that flag decides whether the channel stays active.

Accesses use a simple port. A write strobe, a 3-bit register offset and a size code (0 = byte, 1 = word, 2 or 3 = dword) are presented with right-aligned write data. Read data is combinational from the offset and size.

Top module: `busmaster_regs`

## Requirements
- R1: A write to offset 0 stores only bits 0 (run) and 3 (direction) of the low data byte, and reading offset 0 returns that stored byte.
- R2: A command write whose bit 0 equals the stored run bit raises neither `dma_start` nor `dma_cancel` and leaves `cur_ptr` unchanged.
- R3: A command write that changes the run bit from 1 to 0 raises `dma_cancel` for exactly the following cycle and clears the active status bit.
- R4: A command write that changes the run bit from 0 to 1 loads `cur_ptr` from the table pointer. If the channel was not active, it also sets the active bit and raises `dma_start` for the following cycle. If the channel was already active, no start request is made.
- R5: `host_irq` equals `dev_irq` in the same cycle. A rising edge of `dev_irq` sets status bit 2, and a falling edge leaves that bit unchanged.
- R6: Writes to offsets 4 to 7 update only the byte lanes selected by the offset's low two bits and the size, with data taken right-aligned. Pointer bits [1:0] are always zero.
- R7: Reads at offsets 4 to 7 return the table pointer shifted right by 8 times the low two offset bits and masked to the access size.
- R8: An engine completion sets the active bit to the value of `eng_more`, so the channel stays or becomes active when more work is pending and goes idle otherwise.
- R9: The status byte at offset 1 holds active in bit 0, error in bit 1 and interrupt in bit 2. `eng_err` sets the error bit. Writing one to bit 1 or bit 2 clears that bit, and a status write never changes bit 0.
- R10: After reset, the command byte, the status byte, the table pointer and the current pointer read as zero, and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register offset: 0 command, 1 status, 4-7 table pointer lanes |
| reg_size | input | 2 | Access size: 0 byte, 1 word, 2/3 dword |
| reg_wdata | input | 32 | Right-aligned write data |
| reg_rdata | output | 32 | Combinational read data for the offset and size |
| dev_irq | input | 1 | Interrupt level from the device |
| eng_done | input | 1 | Engine completion strobe |
| eng_more | input | 1 | Engine has more work pending, qualified by eng_done |
| eng_err | input | 1 | Engine error strobe |
| dma_start | output | 1 | One-cycle start request to the engine |
| dma_cancel | output | 1 | One-cycle cancel request to the engine |
| cur_ptr | output | 32 | Current descriptor pointer for the engine |
| host_irq | output | 1 | Interrupt level to the host |

## Verification
The hardest case to reach is a run-bit rise while the channel is already active. Only that case loads the pointer without a start request. Cancelling clears the active bit, so the run bit must first be dropped. An engine completion with `eng_more` high then marks the channel active again while the run bit is still zero. The bench follows exactly that order, moves the table pointer, and then sets the run bit. It expects the new pointer, the active bit unchanged and no start pulse.

// File: rtl/busmaster_regs_pkg.sv
// Shared constants and helpers for the bus-master channel register block.
// Assumes a 32-bit register data path and little-endian byte lanes.
package busmaster_regs_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned OFF_W    = 3;
    localparam int unsigned LANE_W   = 2;
    localparam int unsigned BYTE_W   = 8;

    localparam logic [OFF_W-1:0] OFF_CMD  = 3'd0;
    localparam logic [OFF_W-1:0] OFF_STAT = 3'd1;

    // Command bits that are kept: run (bit 0) and direction (bit 3).
    localparam logic [BYTE_W-1:0] CMD_KEEP = 8'h09;

    localparam int unsigned ST_ACT = 0;
    localparam int unsigned ST_ERR = 1;
    localparam int unsigned ST_INT = 2;

    // Byte-lane mask for an access size code (0 byte, 1 word, else dword).
    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    size_mask = 32'h0000_00FF;
            2'd1:    size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/busmaster_cmd_ctl.sv
// Command register and run control.
// Keeps the run and direction bits and owns the active flag. It issues
// one-cycle start and cancel pulses when the run bit changes and loads the
// current descriptor pointer on a run rise. A command write in the same cycle
// as an engine completion takes precedence over it.
module busmaster_cmd_ctl
    import busmaster_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [BYTE_W-1:0] cmd_wbyte,
    input  logic [DATA_W-1:0] tbl_ptr,
    input  logic              eng_done,
    input  logic              eng_more,
    output logic [BYTE_W-1:0] cmd_q,
    output logic              active_q,
    output logic              start_q,
    output logic              cancel_q,
    output logic [DATA_W-1:0] cur_ptr_q
);
    logic [BYTE_W-1:0] cmd_next;
    logic              run_edge;

    // Masked command value and detection of a run-bit change.
    always_comb begin
        cmd_next = cmd_wbyte & CMD_KEEP;
        run_edge = cmd_we && (cmd_next[0] != cmd_q[0]);
    end

    // Command byte, active flag, request pulses and pointer load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            active_q  <= 1'b0;
            start_q   <= 1'b0;
            cancel_q  <= 1'b0;
            cur_ptr_q <= '0;
        end else begin
            start_q  <= 1'b0;
            cancel_q <= 1'b0;
            if (eng_done) begin
                active_q <= eng_more;
            end
            if (run_edge) begin
                if (!cmd_next[0]) begin
                    cancel_q <= 1'b1;
                    active_q <= 1'b0;
                end else begin
                    cur_ptr_q <= tbl_ptr;
                    if (!active_q) begin
                        active_q <= 1'b1;
                        start_q  <= 1'b1;
                    end
                end
            end
            if (cmd_we) begin
                cmd_q <= cmd_next;
            end
        end
    end
endmodule

// File: rtl/busmaster_stat_ctl.sv
// Sticky status flags: error and interrupt.
// The interrupt flag is set on a rising device interrupt, which is found from
// a one-cycle history of the level. A set beats a clear in the same cycle.
module busmaster_stat_ctl
    import busmaster_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_we,
    input  logic [BYTE_W-1:0] st_wbyte,
    input  logic              dev_irq,
    input  logic              eng_err,
    output logic              err_q,
    output logic              int_q
);
    logic irq_prev_q;

    // History of the device interrupt level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_prev_q <= 1'b0;
        else        irq_prev_q <= dev_irq;
    end

    // Error flag: set by the engine, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            if (st_we && st_wbyte[ST_ERR]) err_q <= 1'b0;
            if (eng_err)                   err_q <= 1'b1;
        end
    end

    // Interrupt flag: set on a rising device interrupt, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q <= 1'b0;
        end else begin
            if (st_we && st_wbyte[ST_INT]) int_q <= 1'b0;
            if (dev_irq && !irq_prev_q)    int_q <= 1'b1;
        end
    end
endmodule

// File: rtl/busmaster_tbl_reg.sv
// Descriptor table pointer with byte-lane access.
// The write data is right-aligned and placed at lane offset*8. The two lowest
// pointer bits always stay zero. The read path returns the lanes shifted down
// and masked to the access size.
module busmaster_tbl_reg
    import busmaster_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [LANE_W-1:0] lane,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] tbl_q,
    output logic [DATA_W-1:0] rd_lanes
);
    logic [4:0]        shamt;
    logic [DATA_W-1:0] szmask;
    logic [DATA_W-1:0] wmask;
    logic [DATA_W-1:0] wpos;

    // Lane shift and masks for the current access.
    always_comb begin
        shamt    = {lane, 3'b000};
        szmask   = size_mask(size);
        wmask    = szmask << shamt;
        wpos     = (wdata & szmask) << shamt;
        rd_lanes = (tbl_q >> shamt) & szmask;
    end

    // Lane merge on write, with the alignment bits forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      tbl_q <= '0;
        else if (tbl_we) tbl_q <= ((tbl_q & ~wmask) | wpos) & ~32'h3;
    end
endmodule

// File: rtl/busmaster_regs.sv
// Top of the bus-master channel register block.
// Decodes the register port into the command, status and table-pointer
// pieces, and muxes read data. It passes the device interrupt straight
// through to the host.
module busmaster_regs
    import busmaster_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [1:0]        reg_size,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              dev_irq,
    input  logic              eng_done,
    input  logic              eng_more,
    input  logic              eng_err,
    output logic              dma_start,
    output logic              dma_cancel,
    output logic [31:0]       cur_ptr,
    output logic              host_irq
);
    logic              cmd_we, st_we, tbl_we;
    logic [BYTE_W-1:0] cmd_w;
    logic              active_w, err_w, int_w;
    logic [DATA_W-1:0] tbl_w, lanes_w;

    // Write decode by register offset.
    always_comb begin
        cmd_we = reg_wr && (reg_addr == OFF_CMD);
        st_we  = reg_wr && (reg_addr == OFF_STAT);
        tbl_we = reg_wr && reg_addr[2];
    end

    busmaster_cmd_ctl u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (cmd_we),
        .cmd_wbyte (reg_wdata[BYTE_W-1:0]),
        .tbl_ptr   (tbl_w),
        .eng_done  (eng_done),
        .eng_more  (eng_more),
        .cmd_q     (cmd_w),
        .active_q  (active_w),
        .start_q   (dma_start),
        .cancel_q  (dma_cancel),
        .cur_ptr_q (cur_ptr)
    );

    busmaster_stat_ctl u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_we    (st_we),
        .st_wbyte (reg_wdata[BYTE_W-1:0]),
        .dev_irq  (dev_irq),
        .eng_err  (eng_err),
        .err_q    (err_w),
        .int_q    (int_w)
    );

    busmaster_tbl_reg u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tbl_we   (tbl_we),
        .lane     (reg_addr[LANE_W-1:0]),
        .size     (reg_size),
        .wdata    (reg_wdata),
        .tbl_q    (tbl_w),
        .rd_lanes (lanes_w)
    );

    // Read data mux by offset.
    always_comb begin
        if (reg_addr[2])                 reg_rdata = lanes_w;
        else if (reg_addr == OFF_CMD)    reg_rdata = {24'h0, cmd_w};
        else if (reg_addr == OFF_STAT)   reg_rdata = {29'h0, int_w, err_w, active_w};
        else                             reg_rdata = '0;
    end

    // Host interrupt follows the device level.
    always_comb host_irq = dev_irq;
endmodule

// File: rtl/busmaster_regs_chk.sv
// Temporal checks on the bus-master register block, bound into its top.
// Observes the register port, the request pulses and internal flags.
module busmaster_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [2:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        dev_irq,
    input logic        eng_done,
    input logic        eng_more,
    input logic        dma_start,
    input logic        dma_cancel,
    input logic [31:0] cur_ptr,
    input logic [31:0] tbl_q,
    input logic        active,
    input logic        int_bit
);
    // R4: a start request follows a command write with the run bit set.
    assert_start_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> $past(reg_wr && reg_addr == 3'd0 && reg_wdata[0]));

    // R4: a start request carries the table pointer and the active flag.
    assert_start_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> (cur_ptr == tbl_q) && active);

    // R3: a cancel follows a run-clearing command write and leaves the channel idle.
    assert_cancel_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dma_cancel |-> $past(reg_wr && reg_addr == 3'd0 && !reg_wdata[0]) && !active);

    // R3: start and cancel are never raised together.
    assert_req_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_start && dma_cancel));

    // R5: a rising device interrupt leaves the interrupt flag set.
    assert_irq_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_irq) |=> int_bit);

    // R8: a completion with nothing pending idles the channel.
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !eng_more && !(reg_wr && reg_addr == 3'd0)) |=> !active);
endmodule

bind busmaster_regs busmaster_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .dev_irq    (dev_irq),
    .eng_done   (eng_done),
    .eng_more   (eng_more),
    .dma_start  (dma_start),
    .dma_cancel (dma_cancel),
    .cur_ptr    (cur_ptr),
    .tbl_q      (tbl_w),
    .active     (active_w),
    .int_bit    (int_w)
);

// File: tb/busmaster_regs_test.sv
`timescale 1ns/100ps
// Directed bench for busmaster_regs: one task per scenario.
module busmaster_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [1:0]  reg_size = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dev_irq = 1'b0;
    logic        eng_done = 1'b0;
    logic        eng_more = 1'b0;
    logic        eng_err = 1'b0;
    logic        dma_start, dma_cancel, host_irq;
    logic [31:0] cur_ptr;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    busmaster_regs uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dev_irq(dev_irq), .eng_done(eng_done), .eng_more(eng_more),
        .eng_err(eng_err), .dma_start(dma_start), .dma_cancel(dma_cancel),
        .cur_ptr(cur_ptr), .host_irq(host_irq)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_size = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_size = s;
        #1 d = reg_rdata;
    endtask

    task automatic done_pulse(input logic more);
        @(negedge clk);
        eng_done = 1'b1; eng_more = more;
        @(negedge clk);
        eng_done = 1'b0; eng_more = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, 2'd0, v); check("R10 cmd", v, 0);
        rd(3'd1, 2'd0, v); check("R10 status", v, 0);
        rd(3'd4, 2'd2, v); check("R10 table", v, 0);
        check("R10 cur_ptr", cur_ptr, 0);
        check("R10 requests", {30'h0, dma_start, dma_cancel}, 0);
    endtask

    task automatic t_table();
        logic [31:0] v;
        wr(3'd4, 2'd2, 32'h1234_5677);
        rd(3'd4, 2'd2, v); check("R6 dword, low bits zero", v, 32'h1234_5674);
        wr(3'd5, 2'd0, 32'hFFFF_FFAB);
        rd(3'd4, 2'd2, v); check("R6 byte lane 1", v, 32'h1234_AB74);
        wr(3'd6, 2'd1, 32'h0000_BEEF);
        rd(3'd4, 2'd2, v); check("R6 word lanes 2-3", v, 32'hBEEF_AB74);
        wr(3'd4, 2'd0, 32'h0000_00FF);
        rd(3'd4, 2'd2, v); check("R6 byte lane 0 low bits", v, 32'hBEEF_ABFC);
        rd(3'd7, 2'd0, v); check("R7 byte at 3", v, 32'h0000_00BE);
        rd(3'd5, 2'd1, v); check("R7 word at 1", v, 32'h0000_EFAB);
    endtask

    task automatic t_start();
        logic [31:0] v;
        wr(3'd0, 2'd0, 32'h0000_00FF);
        check("R4 start pulse", {31'h0, dma_start}, 1);
        check("R4 no cancel", {31'h0, dma_cancel}, 0);
        check("R4 pointer load", cur_ptr, 32'hBEEF_ABFC);
        rd(3'd0, 2'd0, v); check("R1 masked cmd", v, 32'h09);
        check("R4 pulse one cycle", {31'h0, dma_start}, 0);
        rd(3'd1, 2'd0, v); check("R4 active set", v, 32'h01);
    endtask

    task automatic t_same();
        logic [31:0] v;
        wr(3'd4, 2'd2, 32'h0000_1000);
        wr(3'd0, 2'd0, 32'h0000_0001);
        check("R2 no requests", {30'h0, dma_start, dma_cancel}, 0);
        check("R2 pointer kept", cur_ptr, 32'hBEEF_ABFC);
        rd(3'd0, 2'd0, v); check("R1 direction cleared", v, 32'h01);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        wr(3'd0, 2'd0, 32'h0000_0000);
        check("R3 cancel pulse", {31'h0, dma_cancel}, 1);
        check("R3 no start", {31'h0, dma_start}, 0);
        rd(3'd1, 2'd0, v); check("R3 active cleared", v, 0);
        check("R3 pulse one cycle", {31'h0, dma_cancel}, 0);
    endtask

    task automatic t_done();
        logic [31:0] v;
        wr(3'd0, 2'd0, 32'h0000_0001);
        check("R4 restart pointer", cur_ptr, 32'h0000_1000);
        done_pulse(1'b1);
        rd(3'd1, 2'd0, v); check("R8 more keeps active", v, 32'h01);
        done_pulse(1'b0);
        rd(3'd1, 2'd0, v); check("R8 idle on finish", v, 0);
        wr(3'd0, 2'd0, 32'h0000_0000);
        done_pulse(1'b1);
        rd(3'd1, 2'd0, v); check("R8 more sets active", v, 32'h01);
        wr(3'd4, 2'd2, 32'h0000_2000);
        wr(3'd0, 2'd0, 32'h0000_0001);
        check("R4 active rise no start", {30'h0, dma_start, dma_cancel}, 0);
        check("R4 active rise loads ptr", cur_ptr, 32'h0000_2000);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        @(negedge clk); dev_irq = 1'b1;
        #1 check("R5 pass high", {31'h0, host_irq}, 1);
        rd(3'd1, 2'd0, v); check("R5 flag on rise", v, 32'h05);
        wr(3'd1, 2'd0, 32'h0000_0005);
        rd(3'd1, 2'd0, v); check("R9 clear int, active kept", v, 32'h01);
        rd(3'd1, 2'd0, v); check("R5 level high no re-set", v, 32'h01);
        @(negedge clk); dev_irq = 1'b0;
        #1 check("R5 pass low", {31'h0, host_irq}, 0);
        @(negedge clk); dev_irq = 1'b1;
        @(negedge clk); dev_irq = 1'b0;
        rd(3'd1, 2'd0, v); check("R5 fall keeps flag", v, 32'h05);
        wr(3'd1, 2'd0, 32'h0000_0004);
    endtask

    task automatic t_err();
        logic [31:0] v;
        @(negedge clk); eng_err = 1'b1;
        @(negedge clk); eng_err = 1'b0;
        rd(3'd1, 2'd0, v); check("R9 error set", v, 32'h03);
        wr(3'd1, 2'd0, 32'h0000_0004);
        rd(3'd1, 2'd0, v); check("R9 wrong bit keeps error", v, 32'h03);
        wr(3'd1, 2'd0, 32'h0000_0002);
        rd(3'd1, 2'd0, v); check("R9 error cleared", v, 32'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_table();
        t_start();
        t_same();
        t_stop();
        t_done();
        t_irq();
        t_err();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule